// File: doc/BRIEF.md
# Interrupt Control and Status Registers

This block is the processor-facing register set that governs two interrupt sources: a non-maskable interrupt raised at the start of vertical blanking, and a maskable interrupt raised by a horizontal/vertical beam timer. Software writes an enable byte to arm each source and to turn on automatic controller polling. Software reads two flag bytes that report, and clear on read, whether each interrupt event has occurred. A third byte reports live blanking status decoded from the beam counters. Bits a register does not drive return the current open-bus byte, so software sees the same undriven-bit behaviour as on any other unmapped read.

Event pulses from the video timing logic set the flags. The block turns them into one-cycle request pulses for the processor core. Two rules apply at write time. Arming the non-maskable interrupt while its flag is already set produces a request straight away. Leaving only the vertical timer armed while the timer flag is set re-issues the timer request. Disarming both timers cancels the flag and any request about to be issued. Every write to the enable byte also produces a one-cycle lock pulse, so the core can hold off interrupt sampling for an instruction.

A two-bit select picks the register. Reads are combinational. Flag clearing, enable updates and request pulses take effect on the clock edge that ends the access cycle.

Top module: `irq_status_regs`

## Requirements
- R1: A write with select 0 (enable byte) loads NMI enable from data bit 7, vertical timer enable from bit 5, horizontal timer enable from bit 4 and poll enable from bit 0. The values show on `nmi_en`, `vtimer_en`, `htimer_en` and `poll_en` from the next cycle. All four reset to 0.
- R2: A read with select 1 returns {NMI flag, open_bus[6:4], 4'h2}, and the clock edge ending that read clears the NMI flag.
- R3: A read with select 2 returns {IRQ flag, open_bus[6:0]}, and the clock edge ending that read clears the IRQ flag.
- R4: An `nmi_event` or `irq_event` pulse in the same cycle as a clearing read of its flag leaves the flag set.
- R5: An `nmi_event` while NMI enable is 1 gives `nmi_req` high for exactly the next cycle. While NMI enable is 0, `nmi_event` gives no request.
- R6: An enable write that takes NMI enable from 0 to 1 while the NMI flag is set gives `nmi_req` high in the next cycle.
- R7: An enable write with bit 5 = 1 and bit 4 = 0 while the IRQ flag is set gives `irq_req` high in the next cycle.
- R8: An enable write with bits 5 and 4 both 0 clears the IRQ flag and suppresses `irq_req` in the next cycle, even when `irq_event` arrives in the same cycle.
- R9: Status read (select 3) bit 7 is 1 when `vcount` is at least the blank start line: 225 with `overscan` = 0, 240 with `overscan` = 1.
- R10: Status bit 0 is 1 for the three lines from the blank start line up to and including start + 2.
- R11: Status bit 6 is 1 when `hcount` <= 2 or `hcount` >= 1096. Status bits 5:1 equal open_bus[5:1].
- R12: `int_lock` is high in the cycle after every enable write and low after any cycle without one.
- R13: A read with select 0 returns open_bus unchanged. Writes with select 1, 2 or 3 leave all enables unchanged.
- R14: An `irq_event` pulse, unless cancelled by R8, gives `irq_req` high for exactly the next cycle and sets the IRQ flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select: 0 enable, 1 NMI flag, 2 IRQ flag, 3 status |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; a flag register read clears its flag |
| wr_data | input | 8 | Write data |
| open_bus | input | 8 | Value returned in undriven bits |
| hcount | input | 11 | Horizontal beam position |
| vcount | input | 9 | Vertical beam line |
| overscan | input | 1 | Selects the later blank start line |
| nmi_event | input | 1 | One-cycle vertical blank start pulse |
| irq_event | input | 1 | One-cycle beam timer match pulse |
| rd_data | output | 8 | Read data for the selected register |
| nmi_req | output | 1 | One-cycle NMI request to the core |
| irq_req | output | 1 | One-cycle IRQ request to the core |
| int_lock | output | 1 | One-cycle interrupt sampling lock after an enable write |
| nmi_en | output | 1 | NMI enable |
| vtimer_en | output | 1 | Vertical timer IRQ enable |
| htimer_en | output | 1 | Horizontal timer IRQ enable |
| poll_en | output | 1 | Automatic controller polling enable |

## Verification
The status byte is tried on beam positions clustered on each boundary: lines 224 through 228 and 239 through 243 under both overscan settings, and columns 2/3 and 1095/1096. These show an off-by-one in the blank start, in the three-line poll window or in either blanking edge. Enable writes run over all combinations of the two timer bits with the IRQ flag both set and clear. This separates the re-trigger rule from the cancel rule, including a cancel that coincides with a timer event. Event pulses that land on a clearing read show whether set or clear wins. Random open-bus bytes on every read show a constant driven into an undriven bit.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_NMI_FLAG = 2'd1,
    SEL_IRQ_FLAG = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_NMI_EN = 7;
  localparam int unsigned BIT_VTIM_EN = 5;
  localparam int unsigned BIT_HTIM_EN = 4;
  localparam int unsigned BIT_POLL_EN = 0;

  // Line at which vertical blanking begins for the given mode.
  function automatic int unsigned blank_start(input logic over,
                                              input int unsigned norm_line,
                                              input int unsigned over_line);
    return over ? over_line : norm_line;
  endfunction

  function automatic logic in_vblank(input int unsigned line,
                                     input int unsigned start);
    return line >= start;
  endfunction

  function automatic logic in_poll_window(input int unsigned line,
                                          input int unsigned start,
                                          input int unsigned lines);
    return (line >= start) && (line < start + lines);
  endfunction

  function automatic logic in_hblank(input int unsigned col,
                                     input int unsigned lead,
                                     input int unsigned trail);
    return (col <= lead) || (col >= trail);
  endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic flag_o
);

  logic flag_q;

  // Priority: cancel, then event set, then read clear.
  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (kill_i)
      flag_q <= 1'b0;
    else if (set_i)
      flag_q <= 1'b1;
    else if (clr_i)
      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !kill_i) |=> flag_o) else $error("set lost");  // R4
  AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !kill_i) |=> !flag_o) else $error("read clear lost");  // R2, R3
  AST_CANCEL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !flag_o) else $error("cancel lost");  // R8

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       nmi_en_o,
  output logic       vtim_en_o,
  output logic       htim_en_o,
  output logic       poll_en_o,
  output logic       nmi_arm_o,
  output logic       timers_off_o,
  output logic       vtim_only_o,
  output logic       lock_o
);

  logic nmi_en_q, vtim_en_q, htim_en_q, poll_en_q, lock_q;
  logic unused_data_bits;

  assign unused_data_bits = ^{data_i[6], data_i[3:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_en_q  <= 1'b0;
      vtim_en_q <= 1'b0;
      htim_en_q <= 1'b0;
      poll_en_q <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      lock_q <= wr_i;
      if (wr_i) begin
        nmi_en_q  <= data_i[BIT_NMI_EN];
        vtim_en_q <= data_i[BIT_VTIM_EN];
        htim_en_q <= data_i[BIT_HTIM_EN];
        poll_en_q <= data_i[BIT_POLL_EN];
      end
    end
  end

  // Write-time events, decoded from the incoming byte and the held state.
  assign nmi_arm_o    = wr_i && !nmi_en_q && data_i[BIT_NMI_EN];
  assign timers_off_o = wr_i && !data_i[BIT_VTIM_EN] && !data_i[BIT_HTIM_EN];
  assign vtim_only_o  = wr_i && data_i[BIT_VTIM_EN] && !data_i[BIT_HTIM_EN];

  assign nmi_en_o  = nmi_en_q;
  assign vtim_en_o = vtim_en_q;
  assign htim_en_o = htim_en_q;
  assign poll_en_o = poll_en_q;
  assign lock_o    = lock_q;

  AST_ENABLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable({nmi_en_o, vtim_en_o, htim_en_o, poll_en_o}))
    else $error("enables moved without write");  // R13
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (nmi_en_o == $past(data_i[7]) && poll_en_o == $past(data_i[0])))
    else $error("enable load");  // R1
  AST_LOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> lock_o) else $error("lock missing");  // R12
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> !lock_o) else $error("lock spurious");  // R12

endmodule

// File: rtl/beam_status_decode.sv
module beam_status_decode
  import irq_regs_pkg::*;
#(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 9,
  parameter int unsigned VBL_NORM = 225,
  parameter int unsigned VBL_OVER = 240,
  parameter int unsigned POLL_LINES = 3,
  parameter int unsigned HBL_LEAD = 2,
  parameter int unsigned HBL_TRAIL = 1096
) (
  input  logic [HW-1:0] hcount_i,
  input  logic [VW-1:0] vcount_i,
  input  logic          overscan_i,
  input  logic [7:0]    open_bus_i,
  output logic [7:0]    status_o,
  output logic          vblank_o,
  output logic          hblank_o,
  output logic          poll_busy_o
);

  int unsigned start_line;

  always_comb begin
    start_line  = blank_start(overscan_i, VBL_NORM, VBL_OVER);
    vblank_o    = in_vblank(int'(vcount_i), start_line);
    poll_busy_o = in_poll_window(int'(vcount_i), start_line, POLL_LINES);
    hblank_o    = in_hblank(int'(hcount_i), HBL_LEAD, HBL_TRAIL);
    status_o    = {vblank_o, hblank_o, open_bus_i[5:1], poll_busy_o};
  end

  always_comb begin
    if (poll_busy_o)
      AST_POLL_INSIDE_VBLANK: assert (vblank_o) else $error("poll outside vblank");  // R10
  end

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 9,
  parameter logic [3:0]  REVISION = 4'h2,
  parameter int unsigned VBL_NORM = 225,
  parameter int unsigned VBL_OVER = 240,
  parameter int unsigned POLL_LINES = 3,
  parameter int unsigned HBL_LEAD = 2,
  parameter int unsigned HBL_TRAIL = 1096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wr_data,
  input  logic [7:0]    open_bus,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic          overscan,
  input  logic          nmi_event,
  input  logic          irq_event,
  output logic [7:0]    rd_data,
  output logic          nmi_req,
  output logic          irq_req,
  output logic          int_lock,
  output logic          nmi_en,
  output logic          vtimer_en,
  output logic          htimer_en,
  output logic          poll_en
);

  reg_sel_e sel_e;
  logic wr_enable, rd_nmi_flag, rd_irq_flag;
  logic nmi_arm, timers_off, vtim_only;
  logic nmi_flag, irq_flag;
  logic nmi_fire, irq_fire;
  logic nmi_req_q, irq_req_q;
  logic [7:0] status_byte;
  logic vblank, hblank, poll_busy;

  assign sel_e       = reg_sel_e'(sel);
  assign wr_enable   = wr_en && (sel_e == SEL_ENABLE);
  assign rd_nmi_flag = rd_en && (sel_e == SEL_NMI_FLAG);
  assign rd_irq_flag = rd_en && (sel_e == SEL_IRQ_FLAG);

  irq_enable_reg u_enable (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (wr_enable),
    .data_i       (wr_data),
    .nmi_en_o     (nmi_en),
    .vtim_en_o    (vtimer_en),
    .htim_en_o    (htimer_en),
    .poll_en_o    (poll_en),
    .nmi_arm_o    (nmi_arm),
    .timers_off_o (timers_off),
    .vtim_only_o  (vtim_only),
    .lock_o       (int_lock)
  );

  irq_flag_cell u_nmi_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (nmi_event),
    .clr_i  (rd_nmi_flag),
    .kill_i (1'b0),
    .flag_o (nmi_flag)
  );

  irq_flag_cell u_irq_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_event),
    .clr_i  (rd_irq_flag),
    .kill_i (timers_off),
    .flag_o (irq_flag)
  );

  beam_status_decode #(
    .HW (HW), .VW (VW), .VBL_NORM (VBL_NORM), .VBL_OVER (VBL_OVER),
    .POLL_LINES (POLL_LINES), .HBL_LEAD (HBL_LEAD), .HBL_TRAIL (HBL_TRAIL)
  ) u_status (
    .hcount_i    (hcount),
    .vcount_i    (vcount),
    .overscan_i  (overscan),
    .open_bus_i  (open_bus),
    .status_o    (status_byte),
    .vblank_o    (vblank),
    .hblank_o    (hblank),
    .poll_busy_o (poll_busy)
  );

  // Request sources for the next cycle.
  assign nmi_fire = (nmi_event && nmi_en) || (nmi_arm && nmi_flag);
  assign irq_fire = !timers_off && (irq_event || (vtim_only && irq_flag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_req_q <= 1'b0;
      irq_req_q <= 1'b0;
    end else begin
      nmi_req_q <= nmi_fire;
      irq_req_q <= irq_fire;
    end
  end

  assign nmi_req = nmi_req_q;
  assign irq_req = irq_req_q;

  always_comb begin
    unique case (sel_e)
      SEL_NMI_FLAG: rd_data = {nmi_flag, open_bus[6:4], REVISION};
      SEL_IRQ_FLAG: rd_data = {irq_flag, open_bus[6:0]};
      SEL_STATUS:   rd_data = status_byte;
      default:      rd_data = open_bus;
    endcase
  end

  AST_NMI_ARM_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_arm && nmi_flag) |=> nmi_req) else $error("arm edge lost");  // R6
  AST_NMI_EVENT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_event && nmi_en) |=> nmi_req) else $error("nmi lost");  // R5
  AST_NMI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_en && !nmi_arm) |=> !nmi_req) else $error("nmi while masked");  // R5
  AST_IRQ_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (vtim_only && irq_flag) |=> irq_req) else $error("retrigger lost");  // R7
  AST_IRQ_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    timers_off |=> (!irq_req && !irq_flag)) else $error("cancel failed");  // R8
  AST_IRQ_EVENT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event && !timers_off) |=> (irq_req && irq_flag)) else $error("irq lost");  // R14
  AST_STATUS_VBLANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_e == SEL_STATUS) |-> (rd_data[7] == vblank)) else $error("status bit7");  // R9

endmodule

// File: tb/test_irq_status_regs.sv
`timescale 1ns/1ps
module test_irq_status_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = 8'h00, open_bus = 8'h00;
  logic [10:0] hcount = 11'd100;
  logic [8:0]  vcount = 9'd100;
  logic        overscan = 1'b0, nmi_event = 1'b0, irq_event = 1'b0;
  logic [7:0]  rd_data;
  logic        nmi_req, irq_req, int_lock, nmi_en, vtimer_en, htimer_en, poll_en;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] last_rd;

  // Reference state
  logic m_ne, m_vt, m_ht, m_pe, m_nf, m_if, m_nreq, m_ireq, m_lock;

  always #2.5 clk = ~clk;

  irq_status_regs i_irq_status_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .open_bus(open_bus), .hcount(hcount), .vcount(vcount),
    .overscan(overscan), .nmi_event(nmi_event), .irq_event(irq_event),
    .rd_data(rd_data), .nmi_req(nmi_req), .irq_req(irq_req), .int_lock(int_lock),
    .nmi_en(nmi_en), .vtimer_en(vtimer_en), .htimer_en(htimer_en), .poll_en(poll_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Status byte as the requirements describe it.
  function automatic logic [7:0] ref_status(input int h, input int v, input logic os,
                                            input logic [7:0] ob);
    int first;
    logic vb, busy, hb;
    first = os ? 240 : 225;
    vb = !(v < first);
    busy = vb && (v - first < 3);
    hb = !((h > 2) && (h < 1096));
    return {vb, hb, ob[5:1], busy};
  endfunction

  // One access cycle: drive at negedge, check read data, advance the model,
  // then check the registered outputs at the following negedge.
  task automatic tick(input logic [1:0] s, input logic w, input logic r,
                      input logic [7:0] d, input logic [7:0] ob, input int h,
                      input int v, input logic os, input logic ne, input logic ie);
    logic wrc, rise, off, vonly;
    logic [7:0] st;
    string rtag, ntag, itag;
    sel = s; wr_en = w; rd_en = r; wr_data = d; open_bus = ob;
    hcount = 11'(h); vcount = 9'(v); overscan = os; nmi_event = ne; irq_event = ie;
    #1;
    last_rd = rd_data;
    case (s)
      2'd0: chk("R13 enable read", rd_data, ob);
      2'd1: chk("R2 nmi flag read", rd_data, {m_nf, ob[6:4], 4'h2});
      2'd2: chk("R3 irq flag read", rd_data, {m_if, ob[6:0]});
      default: begin
        st = ref_status(h, v, os, ob);
        chk("R9 vblank bit", {7'd0, rd_data[7]}, {7'd0, st[7]});
        chk("R10 poll bit", {7'd0, rd_data[0]}, {7'd0, st[0]});
        chk("R11 hblank/open bits", {2'd0, rd_data[6:1]}, {2'd0, st[6:1]});
      end
    endcase
    wrc = w && (s == 2'd0);
    rise = wrc && !m_ne && d[7];
    off = wrc && (d[5:4] == 2'b00);
    vonly = wrc && (d[5:4] == 2'b10);
    ntag = (rise && m_nf) ? "R6 nmi_req" : "R5 nmi_req";
    itag = off ? "R8 irq_req" : (vonly && m_if) ? "R7 irq_req" : "R14 irq_req";
    rtag = wrc ? "R1 enables" : "R13 enables";
    m_nreq = (ne && m_ne) || (rise && m_nf);
    m_ireq = !off && (ie || (vonly && m_if));
    m_lock = wrc;
    if (ne) m_nf = 1'b1; else if (r && s == 2'd1) m_nf = 1'b0;
    if (off) m_if = 1'b0; else if (ie) m_if = 1'b1; else if (r && s == 2'd2) m_if = 1'b0;
    if (wrc) begin m_ne = d[7]; m_vt = d[5]; m_ht = d[4]; m_pe = d[0]; end
    @(posedge clk);
    @(negedge clk);
    cycles++;
    chk(ntag, {7'd0, nmi_req}, {7'd0, m_nreq});
    chk(itag, {7'd0, irq_req}, {7'd0, m_ireq});
    chk("R12 int_lock", {7'd0, int_lock}, {7'd0, m_lock});
    chk(rtag, {4'd0, nmi_en, vtimer_en, htimer_en, poll_en}, {4'd0, m_ne, m_vt, m_ht, m_pe});
  endtask

  task automatic idle();
    tick(2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 500, 100, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic int pick_h(input int unsigned r);
    int tbl[8] = '{0, 1, 2, 3, 1095, 1096, 1097, 1339};
    return (r[2:0] < 3'd5) ? tbl[r[5:3]] : int'(r[16:6] % 1364);
  endfunction

  function automatic int pick_v(input int unsigned r);
    int tbl[12] = '{224, 225, 226, 227, 228, 239, 240, 241, 242, 243, 0, 261};
    return (r[1:0] != 2'd0) ? tbl[r[7:4] % 12] : int'(r[16:8] % 262);
  endfunction

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned r;
    m_ne = 0; m_vt = 0; m_ht = 0; m_pe = 0; m_nf = 0; m_if = 0;
    m_nreq = 0; m_ireq = 0; m_lock = 0;
    void'($urandom(32'd1375));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state (R1)
    chk("R1 reset enables", {4'd0, nmi_en, vtimer_en, htimer_en, poll_en}, 8'h00);
    chk("R5 reset nmi_req", {7'd0, nmi_req}, 8'h00);
    // R2: reset flag read, revision nibble and open bus
    tick(2'd1, 1'b0, 1'b1, 8'h00, 8'hFF, 500, 100, 1'b0, 1'b0, 1'b0);
    chk("R2 directed", last_rd, 8'h72);
    // R1: enable load
    tick(2'd0, 1'b1, 1'b0, 8'hB1, 8'h00, 500, 100, 1'b0, 1'b0, 1'b0);
    chk("R1 directed", {4'd0, nmi_en, vtimer_en, htimer_en, poll_en}, 8'h0F);
    // R13: write to flag register leaves enables alone
    tick(2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 500, 100, 1'b0, 1'b0, 1'b0);
    chk("R13 directed", {4'd0, nmi_en, vtimer_en, htimer_en, poll_en}, 8'h0F);
    // R5/R6: masked event sets flag only, arming then fires
    tick(2'd0, 1'b1, 1'b0, 8'h30, 8'h00, 500, 100, 1'b0, 1'b0, 1'b0);
    tick(2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 500, 225, 1'b0, 1'b1, 1'b0);
    chk("R5 masked", {7'd0, nmi_req}, 8'h00);
    tick(2'd0, 1'b1, 1'b0, 8'hB0, 8'h00, 500, 225, 1'b0, 1'b0, 1'b0);
    chk("R6 directed", {7'd0, nmi_req}, 8'h01);
    // R4: event and clearing read together
    tick(2'd1, 1'b0, 1'b1, 8'h00, 8'h00, 500, 225, 1'b0, 1'b1, 1'b0);
    chk("R5 enabled", {7'd0, nmi_req}, 8'h01);
    tick(2'd1, 1'b0, 1'b1, 8'h00, 8'h00, 500, 225, 1'b0, 1'b0, 1'b0);
    chk("R4 directed", last_rd, 8'h82);
    tick(2'd1, 1'b0, 1'b1, 8'h00, 8'h00, 500, 225, 1'b0, 1'b0, 1'b0);
    chk("R2 cleared", last_rd, 8'h02);
    // R14/R7/R8: timer flag paths
    tick(2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 500, 100, 1'b0, 1'b0, 1'b1);
    chk("R14 directed", {7'd0, irq_req}, 8'h01);
    tick(2'd0, 1'b1, 1'b0, 8'h20, 8'h00, 500, 100, 1'b0, 1'b0, 1'b0);
    chk("R7 directed", {7'd0, irq_req}, 8'h01);
    tick(2'd0, 1'b1, 1'b0, 8'h00, 8'h00, 500, 100, 1'b0, 1'b0, 1'b1);
    chk("R8 directed", {7'd0, irq_req}, 8'h00);
    tick(2'd2, 1'b0, 1'b1, 8'h00, 8'h55, 500, 100, 1'b0, 1'b0, 1'b0);
    chk("R8 flag cleared", last_rd, 8'h55);
    idle();
    chk("R12 quiet", {7'd0, int_lock}, 8'h00);
    // R9/R10/R11 boundaries in both modes
    for (int os = 0; os < 2; os++)
      for (int k = 0; k < 6; k++)
        tick(2'd3, 1'b0, 1'b1, 8'h00, 8'hA5, (k % 2 == 0) ? 2 + k / 2 * 547 : 3 + k / 2 * 546,
             (os != 0) ? 238 + k : 223 + k, os[0], 1'b0, 1'b0);
    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      tick(r[1:0], r[4:2] == 3'd0, r[5], (r[6] ? {r[7], 1'b0, r[9:8], 3'd0, r[10]} : r[27:20]),
           8'($urandom), pick_h($urandom), pick_v($urandom), r[11],
           r[14:12] == 3'd0, r[17:15] == 3'd0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule